// File: doc/BRIEF.md
# Training Message Mailbox

The mailbox sits between an embedded memory-interface training engine and a host CPU. The engine hands over one 32-bit word at a time on a valid/ready interface. A flag with each word says whether it is a single major code or a streamed word. The host sees the word through a small register bus with single-cycle reads and writes. It polls an active-low pending bit, reads the word as two 16-bit halves, and then runs a four-phase acknowledge handshake before the next word may enter.

The block follows the message sequence as it passes through. A major code of 0x08 opens a streamed sequence. The first streamed word of that sequence is a string index, and its low 16 bits give the number of argument words that follow. The block counts those arguments down. Major codes 0x07 (pass) and 0xFF (fail) end training. They set a sticky done output and a pass/fail output.

Top module: `train_mbox`

## Requirements
- R1: After reset, status bit 0 reads 1, the acknowledge register reads 1, both data registers read 0, eng_ready_o is 1, and done_o, pass_o, stream_o and args_left_o are all 0.
- R2: The engine word is accepted on a clock edge where eng_valid_i and eng_ready_o are both high. From the next cycle, status bit 0 reads 0 and the data registers are loaded. The low register (address 1) holds bits 15:0 of the word. For a streamed word the high register (address 2) holds bits 31:16. For a major word the high register reads 0.
- R3: While a word is pending, a write of 0 to bit 0 of the acknowledge register (address 3) makes status bit 0 read 1 from the next cycle. The acknowledge register then reads 0.
- R4: A later write of 1 to the acknowledge register closes the handshake, and eng_ready_o is 1 from the next cycle.
- R5: eng_ready_o is 0 while a word is pending. A valid word offered in that time is not taken, and the data registers keep the pending word.
- R6: While the acknowledge register holds 0, eng_ready_o is 0, even when no word is pending. The next word is presented only after the register returns to 1.
- R7: After major code 0x08, stream_o is 1. The next streamed word loads bits 15:0 into args_left_o. Each further streamed word decrements args_left_o. stream_o falls when the count reaches 0, or right after an index word whose low half is 0.
- R8: Major code 0x07 sets done_o=1 and pass_o=1. Major code 0xFF sets done_o=1 and pass_o=0. Codes are compared on bits 15:0. Other major codes leave done_o and pass_o unchanged.
- R9: done_o and pass_o keep the first terminal code seen until reset. A later terminal code changes neither output.
- R10: A major word that arrives inside a streamed sequence ends that sequence (stream_o=0, args_left_o=0) and is then decoded as a normal major code. A streamed word that arrives outside a sequence is delivered to the host but leaves stream_o and args_left_o at 0.
- R11: Writes to addresses 0, 1 and 2 have no effect. Reads return status at address 0, low data at address 1, high data at address 2 and acknowledge at address 3, with all unused bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| eng_valid_i | input | 1 | Engine word valid |
| eng_stream_i | input | 1 | 1 = streamed word, 0 = major code |
| eng_data_i | input | 32 | Engine word |
| eng_ready_o | output | 1 | Mailbox can take a word |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| stream_o | output | 1 | A streamed sequence is in progress |
| args_left_o | output | 16 | Argument words still expected |
| done_o | output | 1 | Sticky: a terminal code has passed |
| pass_o | output | 1 | Result of the first terminal code |

## Verification
The bench offers a second word while one is still pending. A mailbox that ignored ready would overwrite the low register, and the host would read the wrong data. The bench writes acknowledge 0 with the mailbox idle. A design that tied ready to the pending bit alone would take a word in the middle of a handshake. Streams with a zero-length index, and streams cut off by a major code, are checked through args_left_o. A counter that decremented blindly would wrap to 0xFFFF. Two terminal codes are sent in a row, in both orders across resets. A latch that was not sticky would let the second code flip pass_o.

// File: rtl/train_mbox_pkg.sv
package train_mbox_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ACK  = 2'd3;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_PEND  = 2'd1,
    HS_CLOSE = 2'd2
  } hs_state_e;

  typedef enum logic [1:0] {
    SQ_MAJOR = 2'd0,
    SQ_INDEX = 2'd1,
    SQ_ARGS  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/mbox_hs.sv
module mbox_hs
  import train_mbox_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eng_valid_i,
  input  logic ack_wr_i,
  input  logic ack_bit_i,
  output logic accept_o,
  output logic pending_o,
  output logic ack_q_o,
  output logic eng_ready_o
);
  hs_state_e state_q, state_d;
  logic      ack_q;

  assign eng_ready_o = (state_q == HS_IDLE) && ack_q;
  assign accept_o    = eng_valid_i && eng_ready_o;
  assign pending_o   = (state_q == HS_PEND);
  assign ack_q_o     = ack_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:  if (accept_o) state_d = HS_PEND;
      HS_PEND:  if (ack_wr_i && !ack_bit_i) state_d = HS_CLOSE;
      HS_CLOSE: if (ack_wr_i && ack_bit_i) state_d = HS_IDLE;
      default:  state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      ack_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (ack_wr_i) ack_q <= ack_bit_i;
    end
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import train_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              stream_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pending_i,
  input  logic              ack_q_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - HALF_W;

  logic [HALF_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (accept_i) begin
      lo_q <= data_i[HALF_W-1:0];
      hi_q <= stream_i ? data_i[DATA_W-1:HALF_W] : '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_STAT: rdata_o[0] = ~pending_i;
      ADDR_LO:   rdata_o    = {{PAD_W{1'b0}}, lo_q};
      ADDR_HI:   rdata_o    = {{PAD_W{1'b0}}, hi_q};
      ADDR_ACK:  rdata_o[0] = ack_q_i;
      default:   rdata_o    = '0;
    endcase
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import train_mbox_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter logic [HALF_W-1:0] CODE_STREAM = 16'h0008,
  parameter logic [HALF_W-1:0] CODE_PASS   = 16'h0007,
  parameter logic [HALF_W-1:0] CODE_FAIL   = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              stream_i,
  input  logic [HALF_W-1:0] word_lo_i,
  output logic              stream_o,
  output logic [HALF_W-1:0] args_left_o,
  output logic              done_o,
  output logic              pass_o
);
  sq_state_e         phase_q;
  logic [HALF_W-1:0] cnt_q;
  logic              done_q, pass_q;
  logic              is_pass, is_fail;

  assign is_pass = (word_lo_i == CODE_PASS);
  assign is_fail = (word_lo_i == CODE_FAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= SQ_MAJOR;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else if (accept_i) begin
      if (!stream_i) begin
        // major word always restarts the tracker
        cnt_q   <= '0;
        phase_q <= (word_lo_i == CODE_STREAM) ? SQ_INDEX : SQ_MAJOR;
        if (!done_q && (is_pass || is_fail)) begin
          done_q <= 1'b1;
          pass_q <= is_pass;
        end
      end else begin
        unique case (phase_q)
          SQ_INDEX: begin
            cnt_q   <= word_lo_i;
            phase_q <= (word_lo_i == '0) ? SQ_MAJOR : SQ_ARGS;
          end
          SQ_ARGS: begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == HALF_W'(1)) phase_q <= SQ_MAJOR;
          end
          default: ;
        endcase
      end
    end
  end

  assign stream_o    = (phase_q != SQ_MAJOR);
  assign args_left_o = cnt_q;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
endmodule

// File: rtl/train_mbox.sv
module train_mbox
  import train_mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = DATA_W / 2,
  parameter logic [HALF_W-1:0] CODE_STREAM = 16'h0008,
  parameter logic [HALF_W-1:0] CODE_PASS   = 16'h0007,
  parameter logic [HALF_W-1:0] CODE_FAIL   = 16'h00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_valid_i,
  input  logic              eng_stream_i,
  input  logic [DATA_W-1:0] eng_data_i,
  output logic              eng_ready_o,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              stream_o,
  output logic [HALF_W-1:0] args_left_o,
  output logic              done_o,
  output logic              pass_o
);
  logic accept, pending, ack_q, ack_wr;

  assign ack_wr = reg_wr_i && (reg_addr_i == ADDR_ACK);

  mbox_hs u_hs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eng_valid_i (eng_valid_i),
    .ack_wr_i    (ack_wr),
    .ack_bit_i   (reg_wdata_i[0]),
    .accept_o    (accept),
    .pending_o   (pending),
    .ack_q_o     (ack_q),
    .eng_ready_o (eng_ready_o)
  );

  mbox_regs #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .stream_i  (eng_stream_i),
    .data_i    (eng_data_i),
    .pending_i (pending),
    .ack_q_i   (ack_q),
    .addr_i    (reg_addr_i),
    .rdata_o   (reg_rdata_o)
  );

  mbox_seq #(
    .HALF_W(HALF_W), .CODE_STREAM(CODE_STREAM),
    .CODE_PASS(CODE_PASS), .CODE_FAIL(CODE_FAIL)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .stream_i    (eng_stream_i),
    .word_lo_i   (eng_data_i[HALF_W-1:0]),
    .stream_o    (stream_o),
    .args_left_o (args_left_o),
    .done_o      (done_o),
    .pass_o      (pass_o)
  );
endmodule

// File: rtl/train_mbox_chk.sv
module train_mbox_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eng_valid_i,
  input logic              eng_ready_o,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              pend_i,
  input logic              ack_i,
  input logic              stream_o,
  input logic [HALF_W-1:0] args_left_o,
  input logic              done_o,
  input logic              pass_o
);
  p_accept_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_valid_i && eng_ready_o) |=> pend_i);

  p_ack_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && reg_wr_i && reg_addr_i == 2'd3 && !reg_wdata_i[0]) |=> !pend_i);

  p_ready_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> !eng_ready_o);

  p_ack_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |-> !eng_ready_o);

  p_args_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stream_o |-> (args_left_o == '0));

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(pass_o)));
endmodule

bind train_mbox train_mbox_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .eng_valid_i (eng_valid_i),
  .eng_ready_o (eng_ready_o),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .pend_i      (pending),
  .ack_i       (ack_q),
  .stream_o    (stream_o),
  .args_left_o (args_left_o),
  .done_o      (done_o),
  .pass_o      (pass_o)
);

// File: tb/tb_train_mbox.sv
`timescale 1ns/1ps
module tb_train_mbox;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eng_valid_i = 1'b0;
  logic        eng_stream_i = 1'b0;
  logic [31:0] eng_data_i = '0;
  logic        eng_ready_o;
  logic [1:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        stream_o;
  logic [15:0] args_left_o;
  logic        done_o, pass_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  train_mbox dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .eng_valid_i(eng_valid_i), .eng_stream_i(eng_stream_i), .eng_data_i(eng_data_i),
    .eng_ready_o(eng_ready_o),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .stream_o(stream_o), .args_left_o(args_left_o), .done_o(done_o), .pass_o(pass_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr_i = a;
    reg_wr_i   = 1'b0;
    #1 v = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i  = a;
    reg_wdata_i = d;
    reg_wr_i    = 1'b1;
    @(negedge clk);
    reg_wr_i    = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // driver: offers a word and records what the host must read back
  task automatic send(input logic strm, input logic [31:0] d);
    int g = 0;
    exp_q.push_back(strm ? d : {16'h0, d[15:0]});
    @(negedge clk);
    eng_valid_i  = 1'b1;
    eng_stream_i = strm;
    eng_data_i   = d;
    #1;
    while (!eng_ready_o && g < 50) begin
      @(negedge clk);
      #1;
      g++;
    end
    @(negedge clk);
    eng_valid_i = 1'b0;
  endtask

  // monitor on the host side: poll, read both halves, compare, handshake
  task automatic take();
    logic [31:0] v, lo, hi, e;
    int g = 0;
    rd(2'd0, v);
    while (v[0] !== 1'b0 && g < 50) begin
      rd(2'd0, v);
      g++;
    end
    chk("R2 status pending", v, 32'h0);
    rd(2'd1, lo);
    rd(2'd2, hi);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 32'hxxxx_xxxx;
    chk("R2 low data", lo, {16'h0, e[15:0]});
    chk("R2 high data", hi, {16'h0, e[31:16]});
    wr(2'd3, 32'h0);
    rd(2'd0, v);
    chk("R3 status back to 1", v, 32'h1);
    rd(2'd3, v);
    chk("R3 ack reads 0", v, 32'h0);
    chk("R6 ready low mid-handshake", {31'h0, eng_ready_o}, 32'h0);
    wr(2'd3, 32'h1);
    rd(2'd0, v);
    chk("R4 ready after close", {31'h0, eng_ready_o}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(2'd0, v); chk("R1 status", v, 32'h1);
    rd(2'd1, v); chk("R1 low", v, 32'h0);
    rd(2'd2, v); chk("R1 high", v, 32'h0);
    rd(2'd3, v); chk("R1 ack", v, 32'h1);
    chk("R1 outputs", {26'h0, eng_ready_o, done_o, pass_o, stream_o, args_left_o == 16'h0, 1'b0},
        {26'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});

    // R2 R8: plain major, high part dropped, no terminal effect
    send(1'b0, 32'h1234_0005);
    take();
    chk("R8 other code no done", {30'h0, done_o, pass_o}, 32'h0);

    // R5: second word offered while first is pending
    send(1'b1, 32'hCAFE_0011);
    @(negedge clk);
    eng_valid_i = 1'b1; eng_stream_i = 1'b1; eng_data_i = 32'hDEAD_BEEF;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R5 ready low while pending", {31'h0, eng_ready_o}, 32'h0);
    end
    rd(2'd1, v); chk("R5 low kept", v, 32'h0000_0011);
    eng_valid_i = 1'b0;
    take();

    // R6: ack 0 with no pending word blocks ready
    wr(2'd3, 32'h0);
    @(negedge clk); #1;
    chk("R6 ready blocked idle", {31'h0, eng_ready_o}, 32'h0);
    wr(2'd3, 32'h1);
    @(negedge clk); #1;
    chk("R6 ready restored", {31'h0, eng_ready_o}, 32'h1);

    // R11: writes to read-only addresses ignored
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R11 status", v, 32'h1);
    rd(2'd1, v); chk("R11 low", v, 32'h0000_0011);
    rd(2'd2, v); chk("R11 high", v, 32'h0000_CAFE);

    // R10: streamed word outside sequence leaves tracker idle
    chk("R10 outside stream idle", {15'h0, stream_o, args_left_o}, 32'h0);

    // R7: stream with two arguments
    send(1'b0, 32'h0000_0008);
    take();
    chk("R7 stream opens", {31'h0, stream_o}, 32'h1);
    send(1'b1, 32'h0003_0002);
    take();
    chk("R7 count loaded", {16'h0, args_left_o}, 32'h2);
    send(1'b1, 32'hAAAA_5555);
    take();
    chk("R7 count 1", {15'h0, stream_o, args_left_o}, {15'h0, 1'b1, 16'h1});
    send(1'b1, 32'h0102_0304);
    take();
    chk("R7 stream closes", {15'h0, stream_o, args_left_o}, 32'h0);

    // R7: zero-length index
    send(1'b0, 32'h0000_0008);
    take();
    send(1'b1, 32'h7777_0000);
    take();
    chk("R7 empty index ends", {15'h0, stream_o, args_left_o}, 32'h0);

    // R10: major cuts a sequence short
    send(1'b0, 32'h0000_0008);
    take();
    send(1'b1, 32'h0000_0005);
    take();
    send(1'b1, 32'h0000_0009);
    take();
    chk("R10 mid count", {16'h0, args_left_o}, 32'h4);
    send(1'b0, 32'h0000_0005);
    take();
    chk("R10 abandoned", {15'h0, stream_o, args_left_o}, 32'h0);

    // R8 R9: pass then fail
    send(1'b0, 32'h0000_0007);
    take();
    chk("R8 pass", {30'h0, done_o, pass_o}, 32'h3);
    send(1'b0, 32'h0000_00FF);
    take();
    chk("R9 pass sticky", {30'h0, done_o, pass_o}, 32'h3);

    // R8 R9: fail then pass after reset
    do_reset();
    send(1'b0, 32'h0000_00FF);
    take();
    chk("R8 fail", {30'h0, done_o, pass_o}, 32'h2);
    send(1'b0, 32'h0000_0007);
    take();
    chk("R9 fail sticky", {30'h0, done_o, pass_o}, 32'h2);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule